// File: doc/BRIEF.md
# Wordline-Parallel Weight Transfer Scheduler

This block sequences the programming pulses for a resistive crossbar of 24 wordlines by 20 bitlines. Each cell holds a 3-bit weight code in a small internal map, loaded one full wordline row at a time through a write port. Once started, the scheduler visits every wordline in turn. For each wordline it tries each programming level in ascending order. For every level it builds a bitline mask that marks all cells on that wordline sharing the level, so all of them are written by a single pulse.

For each pulse the block presents the selected wordline, a target-voltage code for that wordline, a half-voltage code for the unselected wordlines, and the bitline mask. A mask bit of 1 grounds the bitline so the cell is written; a mask bit of 0 drives the inhibit voltage. Pulse shaping and the analog drivers sit downstream and accept each pulse with a valid/ready handshake. A level that no cell on the wordline uses is skipped without a pulse. Such empty levels are common after pruning.

Code 0 marks a cell that stays in its high-resistance state. Codes 1 to 7 are the programming levels.

Top module: `wl_xfer_sched`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done` and `pulse_valid` are all 0.
- R2: A write with `wr_en` high stores `wr_row` as the codes of wordline `wr_wl`, with bitline b's code in bits [3*b+2:3*b]. A write is ignored while `busy` is 1 or when `wr_wl` is 24 or more.
- R3: `start` sampled while idle makes `busy` rise on the next cycle. `start` sampled while `busy` is 1 has no effect.
- R4: Within a run, pulses come in ascending wordline order (0 to 23). Within each wordline they come in ascending level order (1 to 7).
- R5: `pulse_mask` bit b is 1 (ground) exactly when the code of cell (`pulse_wl`, b) equals the current level; all other bits are 0 (inhibit). Code 0 is never selected.
- R6: A wordline/level pair whose mask would be all zero produces no pulse. It occupies exactly one cycle, and `pulse_valid` stays 0 during it.
- R7: While `pulse_valid` is 1 and `pulse_ready` is 0, all pulse outputs hold. After a cycle with `pulse_valid` and `pulse_ready` both 1, the next pair is presented in the following cycle.
- R8: During a pulse, `pulse_vtgt` equals twice the level and `pulse_vhalf` equals the level, both in units of half a level step.
- R9: After the last pair (wordline 23, level 7) completes, `busy` falls and `done` rises in the same cycle. `done` stays 1 until the next accepted `start`, and it is never 1 together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Map row write strobe |
| wr_wl | input | 5 | Wordline index of the row written |
| wr_row | input | 60 | Twenty 3-bit codes, bitline 0 in the low bits |
| start | input | 1 | Begin a transfer run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| pulse_valid | output | 1 | A pulse is presented |
| pulse_ready | input | 1 | Downstream accepts the pulse |
| pulse_wl | output | 5 | Selected wordline |
| pulse_vtgt | output | 4 | Target voltage code for the selected wordline |
| pulse_vhalf | output | 3 | Half-voltage code for unselected wordlines |
| pulse_mask | output | 20 | Per-bitline ground (1) or inhibit (0) |

## Verification
The bench uses a pruned map in which several levels, and one whole row, are empty. A scheduler that issued pulses for empty levels, or spent the wrong number of cycles on them, would put `pulse_valid` or the cursor out of step with the reference in that stretch. It drops ready at random. A design that advanced on an unaccepted pulse would lose a pulse and fall one pair ahead of the reference. It writes row 23 in mid-run: a map without the lock would later show the new codes in that row's masks. It also issues `start` during a run and a write to wordline index 30, which must change nothing. An all-zero map must finish in exactly 168 cycles with no pulse, which catches any off-by-one at the last wordline or level.

// File: rtl/wl_xfer_pkg.sv
package wl_xfer_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wx_state_e;

endpackage

// File: rtl/wl_xfer_map.sv
module wl_xfer_map #(
  parameter int NUM_WL = 24,
  parameter int NUM_BL = 20,
  parameter int CODE_W = 3,
  localparam int WL_W  = $clog2(NUM_WL),
  localparam int ROW_W = NUM_BL * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             lock,
  input  logic [WL_W-1:0]  wr_wl,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [WL_W-1:0]  rd_wl,
  output logic [ROW_W-1:0] rd_row
);

  logic [ROW_W-1:0] rows [NUM_WL];

  for (genvar r = 0; r < NUM_WL; r++) begin : g_row
    logic [ROW_W-1:0] row_q;
    logic             row_en;

    assign row_en = wr_en && !lock && (wr_wl == WL_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_en) row_q <= wr_row;
    end

    assign rows[r] = row_q;
  end

  assign rd_row = rows[rd_wl];

endmodule

// File: rtl/wl_xfer_match.sv
module wl_xfer_match #(
  parameter int NUM_BL = 20,
  parameter int CODE_W = 3
) (
  input  logic [NUM_BL*CODE_W-1:0] row,
  input  logic [CODE_W-1:0]        level,
  output logic [NUM_BL-1:0]        mask,
  output logic                     any
);

  for (genvar b = 0; b < NUM_BL; b++) begin : g_bl
    assign mask[b] = (level != '0) && (row[b*CODE_W +: CODE_W] == level);
  end

  assign any = |mask;

endmodule

// File: rtl/wl_xfer_seq.sv
module wl_xfer_seq
  import wl_xfer_pkg::*;
#(
  parameter int NUM_WL = 24,
  parameter int CODE_W = 3,
  localparam int WL_W  = $clog2(NUM_WL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mask_any,
  input  logic              pulse_ready,
  output logic              busy,
  output logic              done,
  output logic              pulse_valid,
  output logic [WL_W-1:0]   cur_wl,
  output logic [CODE_W-1:0] cur_lvl
);

  localparam logic [WL_W-1:0]   WL_LAST  = WL_W'(NUM_WL - 1);
  localparam logic [CODE_W-1:0] LVL_LAST = '1;
  localparam logic [CODE_W-1:0] LVL_FIRST = CODE_W'(1);

  wx_state_e         state_q, state_d;
  logic              done_q, done_d;
  logic [WL_W-1:0]   wl_q, wl_d;
  logic [CODE_W-1:0] lvl_q, lvl_d;
  logic              step, last;

  assign step = (state_q == ST_RUN) && (!mask_any || pulse_ready);
  assign last = (wl_q == WL_LAST) && (lvl_q == LVL_LAST);

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    wl_d    = wl_q;
    lvl_d   = lvl_q;
    if (state_q == ST_IDLE) begin
      if (start) begin
        state_d = ST_RUN;
        done_d  = 1'b0;
        wl_d    = '0;
        lvl_d   = LVL_FIRST;
      end
    end else if (step) begin
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else if (lvl_q == LVL_LAST) begin
        wl_d  = wl_q + 1'b1;
        lvl_d = LVL_FIRST;
      end else begin
        lvl_d = lvl_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      wl_q    <= '0;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      wl_q    <= wl_d;
      lvl_q   <= lvl_d;
    end
  end

  assign busy        = (state_q == ST_RUN);
  assign done        = done_q;
  assign pulse_valid = busy && mask_any;
  assign cur_wl      = wl_q;
  assign cur_lvl     = lvl_q;

endmodule

// File: rtl/wl_xfer_sched.sv
module wl_xfer_sched #(
  parameter int NUM_WL = 24,
  parameter int NUM_BL = 20,
  parameter int CODE_W = 3,
  localparam int WL_W  = $clog2(NUM_WL),
  localparam int ROW_W = NUM_BL * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WL_W-1:0]   wr_wl,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pulse_valid,
  input  logic              pulse_ready,
  output logic [WL_W-1:0]   pulse_wl,
  output logic [CODE_W:0]   pulse_vtgt,
  output logic [CODE_W-1:0] pulse_vhalf,
  output logic [NUM_BL-1:0] pulse_mask
);

  logic [ROW_W-1:0]  row;
  logic [WL_W-1:0]   cur_wl;
  logic [CODE_W-1:0] cur_lvl;
  logic              mask_any;

  wl_xfer_map #(.NUM_WL(NUM_WL), .NUM_BL(NUM_BL), .CODE_W(CODE_W)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .lock   (busy),
    .wr_wl  (wr_wl),
    .wr_row (wr_row),
    .rd_wl  (cur_wl),
    .rd_row (row)
  );

  wl_xfer_match #(.NUM_BL(NUM_BL), .CODE_W(CODE_W)) u_match (
    .row   (row),
    .level (cur_lvl),
    .mask  (pulse_mask),
    .any   (mask_any)
  );

  wl_xfer_seq #(.NUM_WL(NUM_WL), .CODE_W(CODE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mask_any    (mask_any),
    .pulse_ready (pulse_ready),
    .busy        (busy),
    .done        (done),
    .pulse_valid (pulse_valid),
    .cur_wl      (cur_wl),
    .cur_lvl     (cur_lvl)
  );

  assign pulse_wl    = cur_wl;
  assign pulse_vtgt  = {cur_lvl, 1'b0};
  assign pulse_vhalf = cur_lvl;

endmodule

// File: rtl/wl_xfer_sched_chk.sv
module wl_xfer_sched_chk #(
  parameter int NUM_WL = 24,
  parameter int NUM_BL = 20,
  parameter int CODE_W = 3,
  localparam int WL_W  = $clog2(NUM_WL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pulse_valid,
  input logic              pulse_ready,
  input logic [WL_W-1:0]   pulse_wl,
  input logic [CODE_W:0]   pulse_vtgt,
  input logic [NUM_BL-1:0] pulse_mask
);

  a_r1_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_valid |-> busy);

  a_r3_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  a_r4_wl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_valid |-> (pulse_wl < WL_W'(NUM_WL)));

  a_r6_no_empty_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_valid |-> (pulse_mask != '0));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_valid && !pulse_ready) |=>
      (pulse_valid && $stable(pulse_wl) && $stable(pulse_mask) && $stable(pulse_vtgt)));

  a_r9_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

bind wl_xfer_sched wl_xfer_sched_chk #(
  .NUM_WL(NUM_WL), .NUM_BL(NUM_BL), .CODE_W(CODE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .pulse_valid (pulse_valid),
  .pulse_ready (pulse_ready),
  .pulse_wl    (pulse_wl),
  .pulse_vtgt  (pulse_vtgt),
  .pulse_mask  (pulse_mask)
);

// File: tb/wl_xfer_sched_test.sv
module wl_xfer_sched_test;

  localparam int NWL = 24;
  localparam int NBL = 20;
  localparam int LMAX = 7;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_wl;
  logic [59:0] wr_row;
  logic        start;
  logic        busy, done, pulse_valid;
  logic        pulse_ready;
  logic [4:0]  pulse_wl;
  logic [3:0]  pulse_vtgt;
  logic [2:0]  pulse_vhalf;
  logic [19:0] pulse_mask;

  wl_xfer_sched uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wl(wr_wl), .wr_row(wr_row),
    .start(start), .busy(busy), .done(done), .pulse_valid(pulse_valid),
    .pulse_ready(pulse_ready), .pulse_wl(pulse_wl), .pulse_vtgt(pulse_vtgt),
    .pulse_vhalf(pulse_vhalf), .pulse_mask(pulse_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int ref_map [NWL][NBL];
  int pat     [NWL][NBL];
  bit ref_busy, ref_done;
  int ref_wl, ref_lvl;
  int pulses;

  function automatic logic [19:0] exp_mask(int wl, int lvl);
    logic [19:0] m = '0;
    for (int b = 0; b < NBL; b++) m[b] = (lvl != 0) && (ref_map[wl][b] == lvl);
    return m;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference update at the active edge, using the inputs held there.
  task automatic ref_edge();
    logic [19:0] m;
    if (!rst_n) begin
      ref_busy = 0; ref_done = 0; ref_wl = 0; ref_lvl = 0;
      for (int w = 0; w < NWL; w++) for (int b = 0; b < NBL; b++) ref_map[w][b] = 0;
      return;
    end
    m = exp_mask(ref_wl, ref_lvl);
    if (!ref_busy && wr_en && wr_wl < NWL)
      for (int b = 0; b < NBL; b++) ref_map[wr_wl][b] = int'(wr_row[3*b +: 3]);
    if (!ref_busy) begin
      if (start) begin
        ref_busy = 1; ref_done = 0; ref_wl = 0; ref_lvl = 1;
      end
    end else if (m == '0 || pulse_ready) begin
      if (m != '0) pulses++;
      if (ref_wl == NWL-1 && ref_lvl == LMAX) begin
        ref_busy = 0; ref_done = 1;
      end else if (ref_lvl == LMAX) begin
        ref_wl++; ref_lvl = 1;
      end else begin
        ref_lvl++;
      end
    end
  endtask

  task automatic compare();
    logic [19:0] m;
    bit ev;
    m  = exp_mask(ref_wl, ref_lvl);
    ev = ref_busy && (m != '0);
    chk(busy === ref_busy, "R3 busy", busy, ref_busy);
    chk(done === ref_done, "R9 done", done, ref_done);
    chk(pulse_valid === ev, "R6 pulse_valid", pulse_valid, ev);
    if (ev && pulse_valid) begin
      chk(pulse_wl == ref_wl, "R4 R7 pulse_wl", pulse_wl, ref_wl);
      chk(pulse_mask == m, "R5 R2 pulse_mask", pulse_mask, m);
      chk(pulse_vtgt == 2*ref_lvl, "R8 pulse_vtgt", pulse_vtgt, 2*ref_lvl);
      chk(pulse_vhalf == ref_lvl, "R8 pulse_vhalf", pulse_vhalf, ref_lvl);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    ref_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic write_row(int wl);
    wr_en = 1; wr_wl = 5'(wl);
    for (int b = 0; b < NBL; b++) wr_row[3*b +: 3] = 3'(pat[wl % NWL][b]);
    tick();
    wr_en = 0;
  endtask

  task automatic load_all();
    for (int w = 0; w < NWL; w++) write_row(w);
  endtask

  // mode 0: ready always; mode 1: random ready; mode 2: random ready plus disturbances
  task automatic run(int mode, int exp_cycles);
    int cyc = 0;
    pulses = 0;
    start = 1; pulse_ready = 1;
    tick();
    start = 0;
    while (ref_busy && cyc < 5000) begin
      pulse_ready = (mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      if (mode == 2 && cyc == 3) begin
        wr_en = 1; wr_wl = 5'd23; wr_row = '1;  // R2: must be ignored while busy
      end else begin
        wr_en = 0;
      end
      start = (mode == 2 && cyc == 10);        // R3: must be ignored while busy
      tick();
      cyc++;
    end
    wr_en = 0; start = 0; pulse_ready = 1;
    chk(cyc < 5000, "R9 run finishes", cyc, 0);
    if (exp_cycles >= 0) chk(cyc == exp_cycles, "R6 empty-level cycle count", cyc, exp_cycles);
    chk(done === 1'b1 && busy === 1'b0, "R9 done after run", {done, busy}, 2'b10);
    repeat (3) tick();
    chk(done === 1'b1, "R9 done held", done, 1);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_wl = '0; wr_row = '0; start = 0; pulse_ready = 1;
    ref_edge();
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && pulse_valid === 1'b0, "R1 reset idle",
        {busy, done, pulse_valid}, 0);
    tick(); tick();
    rst_n = 1;
    tick();
    chk(busy === 1'b0 && done === 1'b0 && pulse_valid === 1'b0, "R1 after reset",
        {busy, done, pulse_valid}, 0);

    // Empty map: 24*7 one-cycle steps, no pulse at all
    run(0, NWL*LMAX);
    chk(pulses == 0, "R5 R6 no pulse for code 0", pulses, 0);

    // Dense pattern, every level present, ready always high
    for (int w = 0; w < NWL; w++) for (int b = 0; b < NBL; b++) pat[w][b] = (w*5 + b*3) % 8;
    load_all();
    run(0, -1);

    // Pruned pattern: levels 2, 4 and 6 absent, wordline 5 all zero; random stalls
    for (int w = 0; w < NWL; w++)
      for (int b = 0; b < NBL; b++) begin
        int v = (w*7 + b*11) % 8;
        pat[w][b] = (w == 5 || v == 2 || v == 4 || v == 6) ? 0 : v;
      end
    load_all();
    run(1, -1);

    // Out-of-range write index is ignored (R2); then a disturbed run
    pat[6][0] = 7;
    write_row(30);
    run(2, -1);
    run(1, -1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule